// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Aligner

This block sits between an instruction fetch buffer and a decoder. It receives a stream of 16-bit instruction parcels, one or two per cycle, and finds where each instruction starts and ends. It reads only the low bits of an instruction's first parcel to learn its length: 1, 2, 3 or 4 parcels, or an extended form of 5 + n parcels. Each complete instruction leaves through a registered output slot. The first parcel sits in the low bits of the slot, and a parcel count comes with it.

Short and long instructions may be mixed freely, so the length is worked out again at every instruction boundary. Parcels of an incomplete instruction wait in an internal queue until the rest arrive. Both sides use valid/ready handshakes, and back-pressure on either side loses no data. Some length codes cannot be delivered: the reserved extended code, and extended lengths that do not fit the output slot. For these the block emits the single first parcel with an illegal flag and steps past it. A synchronous flush discards everything held and treats the next accepted parcel as the start of an instruction.

Top module: `parcel_aligner`

## Requirements
- R1: A first parcel whose bits [1:0] are not 2'b11 starts a 1-parcel instruction.
- R2: A first parcel with bits [1:0] = 2'b11 and bits [4:2] not 3'b111 starts a 2-parcel instruction.
- R3: A first parcel with bits [5:0] = 6'b011111 starts a 3-parcel instruction. A first parcel with bits [6:0] = 7'b0111111 starts a 4-parcel instruction.
- R4: A first parcel with bits [6:0] all ones starts an instruction of 5 + n parcels, where n = bits [10:7], provided that 5 + n is at most MAXP (12).
- R5: If n = 15, or if 5 + n exceeds MAXP, the block emits the first parcel alone with out_illegal = 1 and out_parcels = 1. The next parcel is treated as an instruction start.
- R6: An emitted instruction has its first parcel in out_insn[15:0], its second parcel in [31:16], and so on. out_parcels is the parcel count (1 to 12), and every out_insn bit above 16 × out_parcels is 0.
- R7: Instructions leave in stream order. Each leaves only after all of its parcels have been accepted, and no parcel is lost or repeated under input or output stalls.
- R8: When in_valid and in_ready are both 1, the input accepts in_data[15:0] as the earlier parcel and, if in_two = 1, in_data[31:16] as the next. in_ready is 0 while flush is 1, and also while fewer than two queue slots are free.
- R9: While out_valid = 1 and out_ready = 0, the output holds out_insn, out_parcels and out_illegal unchanged on the next cycle.
- R10: A flush drops all held parcels and any pending output, so out_valid is 0 on the next cycle. The next parcel accepted after the flush starts an instruction.
- R11: After reset, out_valid is 0 and in_ready is 1.
- R12: When the next instruction is already complete in the queue and out_ready stays 1, the block delivers one instruction every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous discard of all held parcels and output |
| in_valid | input | 1 | Input parcels are offered |
| in_two | input | 1 | Both parcels of in_data are offered |
| in_data | input | 32 | Earlier parcel in [15:0], next parcel in [31:16] |
| in_ready | output | 1 | Input can take up to two parcels this cycle |
| out_valid | output | 1 | out_insn holds a complete instruction |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 192 | Instruction, first parcel in the low bits, zero-filled above |
| out_parcels | output | 4 | Number of parcels in out_insn |
| out_illegal | output | 1 | Length code of the emitted parcel is reserved or too long |

## Verification
The hardest state to reach from the ports is a full queue that holds an incomplete instruction while the output slot is also stalled. The flush must then remove the partial instruction and still realign correctly on the next input. The bench reaches this state with directed phases. In one, it stalls the output and offers two parcels per cycle until in_ready falls, then releases the output to measure back-to-back delivery. In another, it leaves only the first parcel of a two-parcel instruction queued, behind a held output, and then flushes. Constrained-random stimulus then mixes all length forms, including both kinds of illegal codes, with random input bubbles, single or double parcels, and random output stalls.

// File: rtl/pa_pkg.sv
package pa_pkg;

  localparam int PARCEL_W = 16;

  // length forms recognised from the first parcel
  typedef enum logic [2:0] {
    FORM_P1,
    FORM_P2,
    FORM_P3,
    FORM_P4,
    FORM_EXT
  } pa_form_e;

  // parcel count of the extended form: 5 + n
  function automatic logic [4:0] ext_parcels(input logic [3:0] n);
    return 5'd5 + {1'b0, n};
  endfunction

endpackage

// File: rtl/pa_len_decode.sv
module pa_len_decode #(
  parameter int PW   = 16,
  parameter int MAXP = 12,
  parameter int LW   = $clog2(MAXP + 1)
) (
  input  logic [PW-1:0] parcel,
  output logic [LW-1:0] len,
  output logic          illegal
);
  import pa_pkg::*;

  pa_form_e   form;
  logic [4:0] ext;

  always_comb begin
    if (parcel[1:0] != 2'b11)       form = FORM_P1;
    else if (parcel[4:2] != 3'b111) form = FORM_P2;
    else if (!parcel[5])            form = FORM_P3;
    else if (!parcel[6])            form = FORM_P4;
    else                            form = FORM_EXT;
  end

  always_comb begin
    ext     = ext_parcels(parcel[10:7]);
    illegal = 1'b0;
    len     = LW'(1);
    unique case (form)
      FORM_P1: len = LW'(1);
      FORM_P2: len = LW'(2);
      FORM_P3: len = LW'(3);
      FORM_P4: len = LW'(4);
      default: begin
        if (parcel[10:7] == 4'hF || int'(ext) > MAXP) begin
          illegal = 1'b1;
          len     = LW'(1);
        end else begin
          len = LW'(ext);
        end
      end
    endcase
  end

endmodule

// File: rtl/pa_parcel_queue.sv
module pa_parcel_queue #(
  parameter int PW    = 16,
  parameter int DEPTH = 16,
  parameter int LW    = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               push,
  input  logic               push_two,
  input  logic [2*PW-1:0]    push_data,
  input  logic [LW-1:0]      pop_n,
  output logic [DEPTH*PW-1:0] q,
  output logic [CW-1:0]      count
);

  logic [DEPTH*PW-1:0] q_r, q_nx, shifted;
  logic [CW-1:0]       cnt_r, cnt_nx, base;

  always_comb begin
    shifted = q_r >> (int'(pop_n) * PW);
    base    = cnt_r - CW'(pop_n);
    q_nx    = shifted;
    for (int i = 0; i < DEPTH; i++) begin
      if (push && CW'(i) == base)
        q_nx[i*PW +: PW] = push_data[PW-1:0];
      if (push && push_two && CW'(i) == base + CW'(1))
        q_nx[i*PW +: PW] = push_data[2*PW-1:PW];
    end
    cnt_nx = base + (push ? (push_two ? CW'(2) : CW'(1)) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      q_r   <= '0;
      cnt_r <= '0;
    end else begin
      q_r   <= q_nx;
      cnt_r <= cnt_nx;
    end
  end

  assign q     = q_r;
  assign count = cnt_r;

endmodule

// File: rtl/pa_out_stage.sv
module pa_out_stage #(
  parameter int OW = 192,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          load,
  input  logic [OW-1:0] d_insn,
  input  logic [LW-1:0] d_parcels,
  input  logic          d_illegal,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [OW-1:0] out_insn,
  output logic [LW-1:0] out_parcels,
  output logic          out_illegal
);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid   <= 1'b0;
      out_insn    <= '0;
      out_parcels <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_insn    <= d_insn;
      out_parcels <= d_parcels;
      out_illegal <= d_illegal;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/parcel_aligner.sv
module parcel_aligner #(
  parameter int PW    = 16,
  parameter int MAXP  = 12,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   in_valid,
  input  logic                   in_two,
  input  logic [2*PW-1:0]        in_data,
  output logic                   in_ready,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [MAXP*PW-1:0]     out_insn,
  output logic [$clog2(MAXP+1)-1:0] out_parcels,
  output logic                   out_illegal
);

  localparam int OW = MAXP * PW;
  localparam int LW = $clog2(MAXP + 1);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH*PW-1:0] q;
  logic [CW-1:0]       count;
  logic [LW-1:0]       need;
  logic                head_ill;
  logic                head_ok, slot_free, fire, push;
  logic [LW-1:0]       pop_n;
  logic [OW-1:0]       emit;

  pa_len_decode #(.PW(PW), .MAXP(MAXP), .LW(LW)) u_dec (
    .parcel  (q[PW-1:0]),
    .len     (need),
    .illegal (head_ill)
  );

  assign head_ok   = count >= CW'(need);
  assign slot_free = !out_valid || out_ready;
  assign fire      = slot_free && head_ok && !flush;
  assign pop_n     = fire ? need : '0;
  assign in_ready  = !flush && (count <= CW'(DEPTH - 2));
  assign push      = in_valid && in_ready;

  for (genvar g = 0; g < MAXP; g++) begin : g_mask
    assign emit[g*PW +: PW] = (need > LW'(g)) ? q[g*PW +: PW] : '0;
  end

  pa_parcel_queue #(.PW(PW), .DEPTH(DEPTH), .LW(LW), .CW(CW)) u_q (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (push),
    .push_two  (in_two),
    .push_data (in_data),
    .pop_n     (pop_n),
    .q         (q),
    .count     (count)
  );

  pa_out_stage #(.OW(OW), .LW(LW)) u_out (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .load        (fire),
    .d_insn      (emit),
    .d_parcels   (need),
    .d_illegal   (head_ill),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_insn    (out_insn),
    .out_parcels (out_parcels),
    .out_illegal (out_illegal)
  );

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int PW   = 16,
  parameter int MAXP = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      flush,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [MAXP*PW-1:0]        out_insn,
  input logic [$clog2(MAXP+1)-1:0] out_parcels,
  input logic                      out_illegal
);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=>
      out_valid && $stable(out_insn) && $stable(out_parcels) && $stable(out_illegal));

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  a_r8_no_accept_in_flush: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  a_r5_illegal_single: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_parcels == 1);

  a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_parcels >= 1) && (int'(out_parcels) <= MAXP));

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_insn >> (int'(out_parcels) * PW)) == '0));

  a_r11_reset_empty: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind parcel_aligner pa_checker #(.PW(PW), .MAXP(MAXP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flush       (flush),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_insn    (out_insn),
  .out_parcels (out_parcels),
  .out_illegal (out_illegal)
);

// File: tb/parcel_aligner_test.sv
module parcel_aligner_test;

  localparam int PW = 16, MAXP = 12, DEPTH = 16, SN = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1, flush = 1'b0, in_valid = 1'b0, in_two = 1'b0, out_ready = 1'b0;
  logic [2*PW-1:0]   in_data = '0;
  logic              in_ready, out_valid, out_illegal;
  logic [MAXP*PW-1:0] out_insn;
  logic [3:0]        out_parcels;

  always #2.5 clk = ~clk;

  parcel_aligner #(.PW(PW), .MAXP(MAXP), .DEPTH(DEPTH)) uut (.*);

  logic [15:0] str [SN];
  int str_len = 0, feed_lim = 0, in_ptr = 0, exp_ptr = 0;
  int n_chk = 0, n_bad = 0, n_fire = 0;
  bit hold_pend = 0;
  logic [MAXP*PW-1:0] held_insn;
  logic [3:0] held_n;
  logic held_ill;

  // expected parcel count from first parcel, 0 = illegal
  function automatic int plen(input logic [15:0] p);
    int n;
    if (p[1:0] != 2'b11) return 1;
    if (p[4:2] != 3'b111) return 2;
    if (!p[5]) return 3;
    if (!p[6]) return 4;
    n = int'(p[10:7]);
    if (n == 15 || 5 + n > MAXP) return 0;
    return 5 + n;
  endfunction

  function automatic string rtag(input int l);
    if (l == 0) return "R5";
    if (l == 1) return "R1";
    if (l == 2) return "R2";
    if (l <= 4) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] p);
    str[str_len] = p;
    str_len++;
  endtask

  // append one instruction of a chosen form
  task automatic gen(input int kind);
    logic [15:0] p;
    int n, np;
    p = 16'($urandom);
    case (kind)
      0: begin p[1:0] = 2'($urandom % 3); np = 1; end
      1: begin p[1:0] = 2'b11; p[4:2] = 3'($urandom % 7); np = 2; end
      2: begin p[5:0] = 6'b011111; np = 3; end
      3: begin p[6:0] = 7'b0111111; np = 4; end
      4: begin n = $urandom % 8; p[6:0] = 7'h7F; p[10:7] = 4'(n); np = 5 + n; end
      default: begin n = 8 + ($urandom % 8); p[6:0] = 7'h7F; p[10:7] = 4'(n); np = 1; end
    endcase
    put(p);
    for (int k = 1; k < np; k++) put(16'($urandom));
  endtask

  task automatic step(input bit v, input bit two, input bit rdy, input bit fl);
    int l, np;
    logic [MAXP*PW-1:0] e;
    @(negedge clk);
    if (hold_pend)
      chk(out_valid && out_insn == held_insn && out_parcels == held_n && out_illegal == held_ill,
          "R9", {out_valid, out_insn}, {1'b1, held_insn});
    in_valid  = v && (in_ptr < feed_lim);
    in_two    = two && (in_ptr + 1 < feed_lim);
    in_data   = {str[(in_ptr + 1) % SN], str[in_ptr % SN]};
    out_ready = rdy;
    flush     = fl;
    #1;
    if (out_valid && out_ready && !flush) begin
      n_fire++;
      l  = plen(str[exp_ptr]);
      np = (l == 0) ? 1 : l;
      e  = '0;
      for (int k = 0; k < np; k++) e[k*PW +: PW] = str[(exp_ptr + k) % SN];
      chk(exp_ptr + np <= in_ptr, "R7", 192'(in_ptr), 192'(exp_ptr + np));
      chk(out_parcels == 4'(np) && out_illegal == (l == 0), rtag(l),
          192'({out_illegal, out_parcels}), 192'({l == 0, 4'(np)}));
      chk(out_insn == e, "R6", out_insn, e);
      exp_ptr += np;
    end
    hold_pend = out_valid && !out_ready && !flush;
    held_insn = out_insn; held_n = out_parcels; held_ill = out_illegal;
    if (in_valid && in_ready) in_ptr += in_two ? 2 : 1;
    if (fl) exp_ptr = in_ptr;
  endtask

  task automatic drain(input int maxc);
    for (int c = 0; c < maxc && exp_ptr < str_len; c++) step(1, 1, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int start, acc, f0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);

    // A: fill with output stalled, then back-to-back delivery
    for (int i = 0; i < 20; i++) put(16'(i << 2));
    feed_lim = str_len;
    start = in_ptr;
    repeat (12) step(1, 1, 0, 0);
    acc = in_ptr - start;
    chk(!in_ready, "R8", 192'(in_ready), 0);
    chk(acc >= DEPTH - 1 && acc <= DEPTH + 1, "R8", 192'(acc), 192'(DEPTH));
    f0 = n_fire;
    for (int i = 0; i < acc; i++) step(0, 0, 1, 0);
    chk(n_fire - f0 == acc, "R12", 192'(n_fire - f0), 192'(acc));
    drain(200);

    // B: flush with a held output and a partial instruction queued
    put(16'h0001); put(16'h0002); put(16'h0000); put(16'h0003);
    feed_lim = str_len;
    repeat (6) step(1, 0, 0, 0);
    step(1, 1, 0, 1);
    step(0, 0, 0, 0);
    chk(!out_valid, "R10", 192'(out_valid), 0);
    put(16'h0002); put(16'h0013); put(16'hABCD);
    feed_lim = str_len;
    drain(100);
    chk(exp_ptr == str_len, "R10", 192'(exp_ptr), 192'(str_len));

    // C: one of each form, including both illegal kinds
    put(16'h0001);
    put(16'h0013); put(16'h1111);
    put(16'h001F); put(16'h2222); put(16'h3333);
    put(16'h003F); for (int k = 0; k < 3; k++) put(16'h4440 + 16'(k));
    put(16'h007F); for (int k = 0; k < 4; k++) put(16'h5550 + 16'(k));
    put(16'h03FF); for (int k = 0; k < 11; k++) put(16'h6660 + 16'(k));
    put(16'h7FFF);
    put(16'h047F);
    put(16'h0002);
    feed_lim = str_len;
    drain(200);

    // D: constrained random
    for (int i = 0; i < 500; i++) gen($urandom % 6);
    feed_lim = str_len;
    for (int c = 0; c < 60000 && exp_ptr < str_len; c++)
      step(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) != 0, 0);
    drain(500);
    chk(exp_ptr == str_len && in_ptr == str_len, "R7", 192'(exp_ptr), 192'(str_len));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule